// File: doc/BRIEF.md
# Multidrop Address-Filtering Serial Receiver

This block receives asynchronous serial characters on a shared line. One master station talks to many slave stations over that line. Every character carries a ninth marker bit after its data bits, in the slot where a parity bit would normally sit. A marker of 1 flags an address character and a marker of 0 flags a data character. No parity is computed or checked. The receiver decodes every character on the line, even while its enable input is low. While disabled it stores only address characters and throws away data characters. Software reads a stored address, compares it with its own station address, and raises the enable to collect the data block that follows. While enabled, every character is stored.

Stored characters go into a three-entry holding queue. The head entry is shown on a data port and on a status byte. The status byte reports the head's marker bit, its framing error and its break flag, together with ready, full and a sticky overrun flag. Bit timing comes from a one-cycle tick at sixteen times the bit rate. The start bit is confirmed at its middle, and every later bit is sampled at its centre. The data length can be 5, 6, 7 or 8 bits. An interrupt output follows the ready flag when the mask allows it.

Top module: `mdrop_rx`

## Requirements
- R1: A falling edge on `rxd` starts a character only if the line is still low eight ticks later, at mid start bit. A low pulse shorter than half a bit stores nothing. Each later bit is sampled 16 ticks after the previous sample.
- R2: `len_sel` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives LSB first, and the unused upper bits of `rd_data` read 0.
- R3: While `rx_en` is 0, a character whose marker bit is 1 is stored and sets ready. A character whose marker is 0 is dropped and changes nothing.
- R4: While `rx_en` is 1, every character is stored, whatever its marker bit.
- R5: `rd_stat[5]` shows the marker bit of the head entry.
- R6: If the stop bit is sampled low, `rd_stat[6]` (framing error) is set for that entry.
- R7: A break (data, marker and stop all low) is stored as one entry with data 0 and with `rd_stat[7]` and `rd_stat[6]` set. Reception resumes only after the line returns high.
- R8: The queue holds 3 entries, read out in arrival order. `rd_stat[0]` is set when it is not empty and `rd_stat[1]` when it is full. A pop on an empty queue has no effect.
- R9: A character that would be stored but arrives while the queue is full is lost and sets the sticky `rd_stat[4]`. Entries already queued are kept. A dropped data character does not set overrun. `ovr_clr` clears the flag.
- R10: If a pop and the completion of a stored character fall in the same cycle while the queue is full, the new character is kept and overrun stays clear.
- R11: `irq` is high exactly while ready is set and `irq_mask` is 1.
- R12: After reset, `rd_stat`, `rd_data` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idles high |
| len_sel | input | 2 | Data length select (5 + value bits) |
| rx_en | input | 1 | Store all characters when 1, only address characters when 0 |
| rd_pop | input | 1 | Remove the head entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| irq_mask | input | 1 | Interrupt enable |
| rd_data | output | 8 | Head entry data |
| rd_stat | output | 8 | [7] break, [6] framing, [5] marker, [4] overrun, [1] full, [0] ready |
| irq | output | 1 | Interrupt request |

## Verification
A software pop and a queue write from a finished character can land in the same clock while the queue holds three entries. The bench provokes this by counting its own ticks. It raises `rd_pop` in the cycle right after the stop-bit sample, which is the cycle in which the write lands. It then judges the result at the ports: overrun must stay clear, the queue must still be full, and popping must return the second and third old entries followed by the new one.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_TAG, S_STOP, S_MARK
  } rx_state_e;

  typedef struct packed {
    logic          brk;
    logic          ferr;
    logic          tag;
    logic [DW-1:0] data;
  } rx_frame_t;

  function automatic logic [3:0] len_of(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

endpackage

// File: rtl/mdrop_rx_sampler.sv
module mdrop_rx_sampler
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd_async,
  input  logic [1:0] len_sel,
  output logic      done,
  output rx_frame_t frame
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [1:0]    sync_q;
  logic          rxd_s;
  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          tag_q, tag_d;
  logic          done_q, done_d;
  rx_frame_t     frm_q, frm_d;
  logic [3:0]    nbits;

  assign rxd_s = sync_q[1];
  assign nbits = len_of(len_sel);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    dat_d  = dat_q;
    tag_d  = tag_q;
    done_d = 1'b0;
    frm_d  = frm_q;
    if (tick) begin
      case (st_q)
        S_IDLE: if (!rxd_s) begin
          st_d  = S_START;
          cnt_d = '0;
        end
        S_START: if (cnt_q == HALF) begin
          if (rxd_s) st_d = S_IDLE;
          else begin
            st_d  = S_DATA;
            cnt_d = '0;
            idx_d = '0;
            dat_d = '0;
          end
        end else cnt_d = cnt_q + 1'b1;
        S_DATA: if (cnt_q == LAST) begin
          cnt_d        = '0;
          dat_d[idx_q] = rxd_s;
          idx_d        = idx_q + 3'd1;
          if ({1'b0, idx_q} == nbits - 4'd1) st_d = S_TAG;
        end else cnt_d = cnt_q + 1'b1;
        S_TAG: if (cnt_q == LAST) begin
          cnt_d = '0;
          tag_d = rxd_s;
          st_d  = S_STOP;
        end else cnt_d = cnt_q + 1'b1;
        S_STOP: if (cnt_q == LAST) begin
          cnt_d      = '0;
          done_d     = 1'b1;
          frm_d.data = dat_q;
          frm_d.tag  = tag_q;
          frm_d.ferr = !rxd_s;
          frm_d.brk  = !rxd_s && (dat_q == '0) && !tag_q;
          st_d       = rxd_s ? S_IDLE : S_MARK;
        end else cnt_d = cnt_q + 1'b1;
        S_MARK: if (rxd_s) st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      dat_q  <= '0;
      tag_q  <= 1'b0;
      done_q <= 1'b0;
      frm_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_async};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      dat_q  <= dat_d;
      tag_q  <= tag_d;
      done_q <= done_d;
      frm_q  <= frm_d;
    end
  end

  assign done  = done_q;
  assign frame = frm_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R1
  AST_BRK_HAS_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && frm_q.brk) |-> (frm_q.ferr && frm_q.data == '0)); // R7

endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);

  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [PW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            do_wr, do_rd;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNTW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_rd = rd && !empty;
  assign do_wr = wr && (!full || do_rd);

  always_comb begin
    wp_d  = do_wr ? nxt(wp_q) : wp_q;
    rp_d  = do_rd ? nxt(rp_q) : rp_q;
    cnt_d = cnt_q + CNTW'(do_wr) - CNTW'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> full && $stable(rp_q)); // R8
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd && !wr) |=> empty); // R8

endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] len_sel,
  input  logic       rx_en,
  input  logic       rd_pop,
  input  logic       ovr_clr,
  input  logic       irq_mask,
  output logic [7:0] rd_data,
  output logic [7:0] rd_stat,
  output logic       irq
);

  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int FW   = $bits(rx_frame_t);

  logic            frm_done;
  rx_frame_t       frm;
  logic            keep, ovr_set;
  logic            ovr_q, ovr_d;
  logic            f_full, f_empty;
  logic [CNTW-1:0] f_cnt;
  logic [FW-1:0]   head_raw;
  rx_frame_t       head;

  mdrop_rx_sampler #(.OSR(OSR)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rxd_async (rxd),
    .len_sel   (len_sel),
    .done      (frm_done),
    .frame     (frm)
  );

  assign keep    = frm_done && (rx_en || frm.tag);
  assign ovr_set = keep && f_full && !rd_pop;

  mdrop_rx_fifo #(.DEPTH(DEPTH), .W(FW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (keep),
    .wdata (frm),
    .rd    (rd_pop),
    .rdata (head_raw),
    .count (f_cnt),
    .full  (f_full),
    .empty (f_empty)
  );

  assign head = rx_frame_t'(head_raw);

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_set)      ovr_d = 1'b1;
    else if (ovr_clr) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign rd_data = f_empty ? '0 : head.data;
  assign rd_stat = {head.brk & ~f_empty, head.ferr & ~f_empty, head.tag & ~f_empty,
                    ovr_q, 2'b00, f_full, ~f_empty};
  assign irq     = ~f_empty & irq_mask;

  AST_DROP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !rx_en && !frm.tag && !rd_pop) |=> $stable(f_cnt)); // R3
  AST_KEEP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && rx_en && !f_full && !rd_pop) |=> (f_cnt == $past(f_cnt) + 1'b1)); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && f_full && !rd_pop) |=> (ovr_q && f_full)); // R9
  AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && f_full && rd_pop && !ovr_q && !ovr_clr) |=> (f_full && !ovr_q)); // R10

endmodule

// File: tb/mdrop_rx_bench.sv
module mdrop_rx_bench;

  logic       clk, rst_n, tick16, rxd, rx_en, rd_pop, ovr_clr, irq_mask;
  logic [1:0] len_sel;
  logic [7:0] rd_data, rd_stat;
  logic       irq;
  int         n_chk, n_err;

  // vector: {rx_en, len_sel[1:0], tag, stop_ok, data[7:0]}
  localparam logic [12:0] VEC [9] = '{
    {1'b0, 2'd3, 1'b1, 1'b1, 8'hA5},
    {1'b0, 2'd3, 1'b0, 1'b1, 8'h3C},
    {1'b1, 2'd3, 1'b0, 1'b1, 8'h3C},
    {1'b1, 2'd0, 1'b0, 1'b1, 8'hF3},
    {1'b1, 2'd1, 1'b1, 1'b1, 8'hFF},
    {1'b1, 2'd2, 1'b0, 1'b1, 8'h55},
    {1'b0, 2'd0, 1'b1, 1'b1, 8'h0A},
    {1'b1, 2'd3, 1'b1, 1'b0, 8'h80},
    {1'b0, 2'd3, 1'b0, 1'b0, 8'h81}
  };

  mdrop_rx u_mdrop_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .len_sel(len_sel),
    .rx_en(rx_en), .rd_pop(rd_pop), .ovr_clr(ovr_clr), .irq_mask(irq_mask),
    .rd_data(rd_data), .rd_stat(rd_stat), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_once(input logic pop);
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) begin tick16 = 1'b0; rd_pop = pop; end
    @(negedge clk) rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input logic pop9);
    rxd = v;
    for (int t = 0; t < 16; t++) tick_once(pop9 && t == 9);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic tg, input logic stp, input logic pop_at_stop);
    int n;
    n = 5 + int'(len_sel);
    send_bit(1'b0, 1'b0);
    for (int b = 0; b < n; b++) send_bit(d[b], 1'b0);
    send_bit(tg, 1'b0);
    send_bit(stp, pop_at_stop);
    rxd = 1'b1;
    for (int t = 0; t < 4; t++) tick_once(1'b0);
  endtask

  task automatic pop_one();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; tick16 = 1'b0; rxd = 1'b1; rx_en = 1'b0; rd_pop = 1'b0;
    ovr_clr = 1'b0; irq_mask = 1'b0; len_sel = 2'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 stat", rd_stat, 8'h00);
    check("R12 data", rd_data, 8'h00);
    check("R12 irq", irq, 1'b0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      logic [12:0] v;
      logic        kp;
      logic [7:0]  msk;
      v = VEC[i];
      rx_en = v[12]; len_sel = v[11:10];
      send_frame(v[7:0], v[9], v[8], 1'b0);
      kp  = v[12] | v[9];
      msk = 8'hFF >> (3 - int'(v[11:10]));
      check(v[12] ? "R4 stored" : "R3 filter", rd_stat[0], kp);
      if (kp) begin
        check("R2 data", rd_data, v[7:0] & msk);
        check("R5 tag", rd_stat[5], v[9]);
        check("R6 ferr", rd_stat[6], !v[8]);
        pop_one();
      end
    end

    // R11 interrupt mask
    rx_en = 1'b1; len_sel = 2'd3;
    send_frame(8'h11, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R11 masked", irq, 1'b0);
    irq_mask = 1'b1; @(negedge clk);
    check("R11 unmasked", irq, 1'b1);
    pop_one();
    check("R11 empty", irq, 1'b0);

    // R1 start glitch
    rxd = 1'b0;
    for (int t = 0; t < 4; t++) tick_once(1'b0);
    rxd = 1'b1;
    for (int t = 0; t < 200; t++) tick_once(1'b0);
    check("R1 glitch", rd_stat, 8'h00);

    // R8 pop on empty, then fill
    pop_one();
    check("R8 pop empty", rd_stat, 8'h00);
    send_frame(8'h01, 1'b0, 1'b1, 1'b0);
    send_frame(8'h02, 1'b0, 1'b1, 1'b0);
    send_frame(8'h03, 1'b0, 1'b1, 1'b0);
    check("R8 full", rd_stat[1:0], 2'b11);
    // R9 data frame while disabled and full: no overrun
    rx_en = 1'b0;
    send_frame(8'h44, 1'b0, 1'b1, 1'b0);
    check("R9 dropped no ovr", rd_stat[4], 1'b0);
    // R9 address frame while full: overrun
    send_frame(8'h55, 1'b1, 1'b1, 1'b0);
    check("R9 overrun", rd_stat[4], 1'b1);
    check("R8 order 1", rd_data, 8'h01); pop_one();
    check("R8 order 2", rd_data, 8'h02); pop_one();
    check("R9 kept 3", rd_data, 8'h03); pop_one();
    check("R8 drained", rd_stat[0], 1'b0);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    check("R9 clear", rd_stat[4], 1'b0);

    // R10 pop in the same cycle as a write into a full queue
    rx_en = 1'b1;
    send_frame(8'h21, 1'b0, 1'b1, 1'b0);
    send_frame(8'h22, 1'b0, 1'b1, 1'b0);
    send_frame(8'h23, 1'b0, 1'b1, 1'b0);
    send_frame(8'h24, 1'b1, 1'b1, 1'b1);
    check("R10 no ovr", rd_stat[4], 1'b0);
    check("R10 full", rd_stat[1:0], 2'b11);
    check("R10 entry 2", rd_data, 8'h22); pop_one();
    check("R10 entry 3", rd_data, 8'h23); pop_one();
    check("R10 new", rd_data, 8'h24);
    check("R10 new tag", rd_stat[5], 1'b1); pop_one();

    // R7 break
    rxd = 1'b0;
    for (int t = 0; t < 16 * 14; t++) tick_once(1'b0);
    rxd = 1'b1;
    for (int t = 0; t < 40; t++) tick_once(1'b0);
    check("R7 break stat", rd_stat, 8'hC1);
    check("R7 break data", rd_data, 8'h00);
    pop_one();
    check("R7 single entry", rd_stat[0], 1'b0);
    send_frame(8'h6B, 1'b0, 1'b1, 1'b0);
    check("R7 resume", rd_data, 8'h6B);
    check("R7 resume stat", rd_stat, 8'h01);
    pop_one();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule